// File: doc/BRIEF.md
# Vertical Laplacian Sharpening Filter

This block sharpens an 8-bit pixel stream in the sub-scan (line-to-line) direction. Each accepted pixel is taken as the sample of the newest line, B. Two chained line delays, each as long as one scan line, supply the pixel at the same column one line earlier (the centre, N) and two lines earlier (the previous line, A). The filter forms the vertical second difference 2N-(A+B), scales it by a programmable gain K and adds it back to the centre pixel. The result is clamped into the 8-bit range.

The gain is an unsigned fixed-point value with four integer and four fraction bits, so K runs from 0 to 15.9375 in steps of 1/16. The arithmetic is split over two register stages. A pixel accepted at a clock edge appears on the output two edges later, together with a valid flag. No output is flagged valid until two full lines have entered the delays. Idle cycles, where the input valid is low, do not advance the line delays.

Top module: `sharpen_filter`

## Requirements
- R1: While reset is high and on the first sampling after it is released, pixOutValid is 0 and pixOut is 0.
- R2: The line delays advance only on cycles where pixInValid is 1. N is the pixel accepted LINE_LEN valid samples before B, and A is the one accepted 2*LINE_LEN valid samples before B. Idle cycles in the stream do not change this pairing.
- R3: The first 2*LINE_LEN valid input pixels after reset produce no valid output.
- R4: Once the delays are primed, every valid input accepted at a clock edge yields exactly one output with pixOutValid=1 after the second following edge. Otherwise pixOutValid is 0.
- R5: The output is floor((16*N + K*(2N-A-B))/16), where K is coefK read as unsigned, bits 7:4 the integer part and bits 3:0 the fraction.
- R6: A result below 0 is output as 0.
- R7: A result above 255 is output as 255.
- R8: With coefK equal to 0, the output equals the centre pixel N.
- R9: While pixOutValid is 0, pixOut keeps the value of the last valid output, or 0 if none has been produced since reset.
- R10: The gain applied to a pixel is the coefK value present in the same cycle as that pixel, even when coefK changes on every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| pixIn | input | 8 | Newest-line pixel B |
| pixInValid | input | 1 | pixIn carries a pixel this cycle |
| coefK | input | 8 | Gain K, unsigned 4.4 fixed point |
| pixOut | output | 8 | Sharpened, clamped pixel |
| pixOutValid | output | 1 | pixOut carries a new pixel this cycle |

## Verification
The assertions assume that pixInValid is low while reset is high. They also assume that the input side counts primed samples in the same way as the block, so the relation between input valid and output valid two cycles later can be stated. The bench drives every input at the falling edge, keeps pixInValid low during reset and never leaves it unknown. It mixes valid-rich random streams with idle gaps and directed line patterns. Those patterns drive the difference to both clamp limits, set a zero gain, and change the gain on every cycle.

// File: rtl/sharpen_pkg.sv
package sharpen_pkg;

  // strobes from the control to the datapath
  typedef struct packed {
    logic shiftEn;  // advance both line delays
    logic loadS1;   // capture operands into stage 1
    logic loadOut;  // capture the stage 2 result into the output register
  } sharpenStrobes_t;

endpackage

// File: rtl/sharpen_line_delay.sv
module sharpen_line_delay #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shiftEn,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] dOut
);

  logic [WIDTH-1:0] stageQ [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) stageQ[0] <= '0;
    else if (shiftEn) stageQ[0] <= dIn;
  end

  for (genvar i = 1; i < DEPTH; i++) begin : g_tap
    always_ff @(posedge clk) begin
      if (rst) stageQ[i] <= '0;
      else if (shiftEn) stageQ[i] <= stageQ[i-1];
    end
  end

  // oldest entry: the sample accepted DEPTH shifts earlier
  assign dOut = stageQ[DEPTH-1];

endmodule

// File: rtl/sharpen_ctrl.sv
module sharpen_ctrl
  import sharpen_pkg::*;
#(
  parameter int LINE_LEN = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pixInValid,
  output sharpenStrobes_t strobes,
  output logic            pixOutValid
);

  localparam int WARM  = 2 * LINE_LEN;
  localparam int CNT_W = $clog2(WARM + 1);

  logic [CNT_W-1:0] fillCnt;
  logic             primed;
  logic             s1Valid;

  assign primed = (fillCnt == CNT_W'(WARM));

  always_ff @(posedge clk) begin
    if (rst) fillCnt <= '0;
    else if (pixInValid && !primed) fillCnt <= fillCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1Valid     <= 1'b0;
      pixOutValid <= 1'b0;
    end else begin
      s1Valid     <= pixInValid && primed;
      pixOutValid <= s1Valid;
    end
  end

  always_comb begin
    strobes.shiftEn = pixInValid;
    strobes.loadS1  = pixInValid && primed;
    strobes.loadOut = s1Valid;
  end

endmodule

// File: rtl/sharpen_datapath.sv
module sharpen_datapath
  import sharpen_pkg::*;
#(
  parameter int PIX_W    = 8,
  parameter int K_W      = 8,
  parameter int K_FRAC   = 4,
  parameter int LINE_LEN = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  sharpenStrobes_t  strobes,
  input  logic [PIX_W-1:0] pixIn,
  input  logic [K_W-1:0]   coefK,
  output logic [PIX_W-1:0] pixOut
);

  localparam int DIFF_W = PIX_W + 3;
  localparam int PROD_W = DIFF_W + K_W + 1;
  localparam int ACC_W  = PROD_W + 1;

  logic [PIX_W-1:0] nextPix, curPix, prevPix;

  assign nextPix = pixIn;

  sharpen_line_delay #(.WIDTH(PIX_W), .DEPTH(LINE_LEN)) u_delayCur (
    .clk(clk), .rst(rst), .shiftEn(strobes.shiftEn), .dIn(nextPix), .dOut(curPix)
  );

  sharpen_line_delay #(.WIDTH(PIX_W), .DEPTH(LINE_LEN)) u_delayPrev (
    .clk(clk), .rst(rst), .shiftEn(strobes.shiftEn), .dIn(curPix), .dOut(prevPix)
  );

  // stage 1: vertical second difference
  logic signed [DIFF_W-1:0] twoN, sumAB, diffC;

  always_comb begin
    twoN  = $signed({{(DIFF_W-PIX_W-1){1'b0}}, curPix, 1'b0});
    sumAB = $signed({{(DIFF_W-PIX_W){1'b0}}, prevPix})
          + $signed({{(DIFF_W-PIX_W){1'b0}}, nextPix});
    diffC = twoN - sumAB;
  end

  logic signed [DIFF_W-1:0] diffS1;
  logic [PIX_W-1:0]         curS1;
  logic [K_W-1:0]           kS1;

  always_ff @(posedge clk) begin
    if (rst) begin
      diffS1 <= '0;
      curS1  <= '0;
      kS1    <= '0;
    end else if (strobes.loadS1) begin
      diffS1 <= diffC;
      curS1  <= curPix;
      kS1    <= coefK;
    end
  end

  // stage 2: scale, add back, clamp
  logic signed [PROD_W-1:0] prodC;
  logic signed [ACC_W-1:0]  accC, scaled;
  logic [PIX_W-1:0]         clampC;

  always_comb begin
    prodC  = PROD_W'(diffS1) * $signed({{(PROD_W-K_W){1'b0}}, kS1});
    accC   = ACC_W'(prodC)
           + $signed({{(ACC_W-PIX_W-K_FRAC){1'b0}}, curS1, {K_FRAC{1'b0}}});
    scaled = accC >>> K_FRAC;
    if (scaled[ACC_W-1])             clampC = '0;
    else if (|scaled[ACC_W-2:PIX_W]) clampC = '1;
    else                             clampC = scaled[PIX_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) pixOut <= '0;
    else if (strobes.loadOut) pixOut <= clampC;
  end

endmodule

// File: rtl/sharpen_filter.sv
module sharpen_filter
  import sharpen_pkg::*;
#(
  parameter int PIX_W    = 8,
  parameter int K_W      = 8,
  parameter int K_FRAC   = 4,
  parameter int LINE_LEN = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PIX_W-1:0] pixIn,
  input  logic             pixInValid,
  input  logic [K_W-1:0]   coefK,
  output logic [PIX_W-1:0] pixOut,
  output logic             pixOutValid
);

  sharpenStrobes_t strobes;

  sharpen_ctrl #(.LINE_LEN(LINE_LEN)) u_ctrl (
    .clk(clk), .rst(rst), .pixInValid(pixInValid),
    .strobes(strobes), .pixOutValid(pixOutValid)
  );

  sharpen_datapath #(
    .PIX_W(PIX_W), .K_W(K_W), .K_FRAC(K_FRAC), .LINE_LEN(LINE_LEN)
  ) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes),
    .pixIn(pixIn), .coefK(coefK), .pixOut(pixOut)
  );

endmodule

// File: rtl/sharpen_filter_chk.sv
module sharpen_filter_chk #(
  parameter int PIX_W    = 8,
  parameter int LINE_LEN = 64
) (
  input logic             clk,
  input logic             rst,
  input logic             pixInValid,
  input logic [PIX_W-1:0] pixOut,
  input logic             pixOutValid
);

  localparam int WARM  = 2 * LINE_LEN;
  localparam int CNT_W = $clog2(WARM + 1);

  logic [CNT_W-1:0] seenCnt;
  logic             primedChk;

  assign primedChk = (seenCnt == CNT_W'(WARM));

  always_ff @(posedge clk) begin
    if (rst) seenCnt <= '0;
    else if (pixInValid && !primedChk) seenCnt <= seenCnt + 1'b1;
  end

  AST_NO_EARLY_VALID: assert property (@(posedge clk) disable iff (rst)
    pixOutValid |-> $past(primedChk, 2)); // R3

  AST_VALID_ORIGIN: assert property (@(posedge clk) disable iff (rst)
    pixOutValid |-> $past(pixInValid, 2)); // R4

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    $past(pixInValid && primedChk, 2) |-> pixOutValid); // R4

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !pixOutValid |-> $stable(pixOut)); // R9

endmodule

bind sharpen_filter sharpen_filter_chk #(.PIX_W(PIX_W), .LINE_LEN(LINE_LEN)) u_chk (
  .clk(clk), .rst(rst), .pixInValid(pixInValid),
  .pixOut(pixOut), .pixOutValid(pixOutValid)
);

// File: tb/sharpen_filter_tb.sv
module sharpen_filter_tb;

  localparam int L = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] pixIn = '0;
  logic       pixInValid = 1'b0;
  logic [7:0] coefK = '0;
  logic [7:0] pixOut;
  logic       pixOutValid;

  sharpen_filter #(.LINE_LEN(L)) u_dut (
    .clk(clk), .rst(rst), .pixIn(pixIn), .pixInValid(pixInValid),
    .coefK(coefK), .pixOut(pixOut), .pixOutValid(pixOutValid)
  );

  always #2 clk = ~clk;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  int    hist [0:8191];
  int    idx = 0;
  bit    expV [4];
  int    expP [4];
  string expT [4];
  int    lastExp = 0;
  int    cyc = 0;

  function automatic int refPix(int a, int n, int b, int k);
    int raw;
    raw = (16 * n + k * (2 * n - a - b)) >>> 4;
    if (raw < 0) return 0;
    if (raw > 255) return 255;
    return raw;
  endfunction

  function automatic string refTag(int a, int n, int b, int k);
    int raw;
    raw = (16 * n + k * (2 * n - a - b)) >>> 4;
    if (k == 0) return "R8";
    if (raw < 0) return "R6";
    if (raw > 255) return "R7";
    return "R5";
  endfunction

  task automatic check(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // one cycle: check output due now, then drive a new input
  task automatic step(bit v, int pix, int k, string extra);
    int s, d;
    s = cyc % 4;
    if (expV[s]) begin
      check({expT[s], " valid"}, int'(pixOutValid), 1);
      check(expT[s], int'(pixOut), expP[s]);
      lastExp = expP[s];
    end else begin
      check({expT[s], " idle valid"}, int'(pixOutValid), 0);
      check("R9", int'(pixOut), lastExp);
    end
    d = (cyc + 2) % 4;
    expV[d] = 1'b0;
    expT[d] = "R4";
    pixInValid = v;
    pixIn      = 8'(pix);
    coefK      = 8'(k);
    if (v) begin
      hist[idx] = pix & 255;
      if (idx >= 2 * L) begin
        int a, n;
        a = hist[idx - 2 * L];
        n = hist[idx - L];
        expV[d] = 1'b1;
        expP[d] = refPix(a, n, pix & 255, k);
        expT[d] = {"R4 ", refTag(a, n, pix & 255, k), extra};
      end else begin
        expT[d] = "R3";
      end
      idx++;
    end
    cyc++;
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4; i++) begin
      expV[i] = 1'b0;
      expP[i] = 0;
      expT[i] = "R1";
    end
    repeat (4) @(negedge clk);
    check("R1 valid in reset", int'(pixOutValid), 0);
    check("R1 pixel in reset", int'(pixOut), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 valid after reset", int'(pixOutValid), 0);
    check("R1 pixel after reset", int'(pixOut), 0);

    // ramp with idle gaps, unity gain: line pairing (R2)
    for (int i = 0; i < 300; i++)
      step(($urandom % 4) != 0, (idx * 7 + 3) & 255, 16, " R2");

    // random pixels, gain changed every 64 cycles
    begin
      int k;
      k = $urandom % 256;
      for (int i = 0; i < 600; i++) begin
        if (i % 64 == 0) k = $urandom % 256;
        step(($urandom % 8) != 0, $urandom % 256, k, "");
      end
    end

    // alternating black and white lines: both clamp limits (R6, R7)
    for (int i = 0; i < 200; i++)
      step(1'b1, ((idx / L) % 2 == 1) ? 255 : 0, 16, "");
    for (int i = 0; i < 100; i++)
      step(1'b1, ((idx / L) % 2 == 1) ? 250 : 5, 1, "");

    // gain changing every cycle (R10)
    for (int i = 0; i < 300; i++)
      step(($urandom % 4) != 0, $urandom % 256, $urandom % 256, " R10");

    // zero gain passes the centre (R8)
    for (int i = 0; i < 200; i++)
      step(($urandom % 3) != 0, $urandom % 256, 0, "");

    // drain
    for (int i = 0; i < 6; i++) step(1'b0, 0, 0, "");

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule